// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers four interrupt causes for a small processor core: a timer overflow pulse, an already-detected edge on an external interrupt pin, a change on any of three watched port pins, and a conversion-complete pulse from the analog-to-digital converter. Each cause has a pending flag and a local enable. The three core causes sit directly under a global enable. The converter cause also sits behind a peripheral group enable, so it needs three enables before it can raise a request.

Pending flags record an event whatever the enables hold, and only a software write removes them. The core sees two outputs. `irq_req` asks the core to vector, and is masked by the global enable. `wake` leaves the global enable out, so that a sleeping core can resume on any enabled pending cause. When the core takes an interrupt it pulses `irq_taken`, which drops the global enable. Its return pulse `irq_return` raises the global enable again.

Software reaches three byte registers through a plain, single-cycle register port. Reads are combinational and writes land on the next clock edge. The port has no handshake because every access completes at once. The pin-change detector compares the watched pins against a snapshot that is refreshed on each port read, which the `port_rd` strobe signals.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every enable bit, every flag bit and the port-pin snapshot are 0. All four register addresses read 0x00, and `irq_req` and `wake` are low.
- R2: The control byte is at address 0. Its bits, from bit 7 down to bit 0, are: global enable, peripheral group enable, timer enable, external-pin enable, pin-change enable, timer flag, external flag, pin-change flag. A write loads all eight bits and a read returns them.
- R3: A pulse on `tmr_ovf`, `ext_edge` or `adc_done` sets the matching flag on the next clock edge, whatever value any enable bit holds.
- R4: A flag is cleared only when software writes 0 to it. If a write of 0 and a set event fall in the same cycle, the flag ends up set.
- R5: The converter flag is bit 6 of the byte at address 1, and its enable is bit 6 of the byte at address 2. All other bits of both bytes read 0, and writes to those bits have no effect.
- R6: On each clock edge at which `port_pins` differs from the snapshot, the pin-change flag is set. A cycle with `port_rd` high loads the current `port_pins` into the snapshot.
- R7: `irq_req` is high exactly when the global enable is 1 and at least one of these holds: the timer enable and flag are both 1; the external enable and flag are both 1; the pin-change enable and flag are both 1; the peripheral group enable, the converter enable and the converter flag are all 1.
- R8: `wake` follows the same rule as `irq_req` with the global enable left out, so `irq_req` implies `wake`.
- R9: `irq_taken` clears the global enable on the next edge, and `irq_return` sets it. `irq_taken` wins over `irq_return` and over a software write to the control byte in the same cycle. `irq_return` wins over the software write.
- R10: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 peripheral flags, 2 peripheral enables, 3 unused) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| ext_edge | input | 1 | External interrupt pin edge event pulse |
| adc_done | input | 1 | Conversion complete event pulse |
| port_pins | input | 3 | Synchronised levels of the watched port pins 0, 1 and 3 |
| port_rd | input | 1 | Port read strobe; refreshes the pin snapshot |
| irq_taken | input | 1 | Core has vectored to the interrupt |
| irq_return | input | 1 | Core returns from the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake from sleep request, not masked by the global enable |

## Verification
Assertions check on every cycle the properties that do not depend on register contents:
- an event always leaves its flag set on the following edge;
- a pin mismatch always raises the pin-change flag;
- `irq_taken` and `irq_return` always move the global enable as required;
- `irq_req` never rises without `wake`;
- the unused peripheral bits always read zero.

The full request and wake truth table can only be shown by the bench. It sweeps every control byte value against every combination of the converter enable and flag. Only the bench scenarios show these behaviours:
- write-versus-event collisions;
- the re-arming of the pin-change flag until a port read;
- precedence among simultaneous strobes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // control byte bit positions (software visible)
  localparam int CTL_GIE  = 7;
  localparam int CTL_PEIE = 6;
  localparam int CTL_TIE  = 5;
  localparam int CTL_XIE  = 4;
  localparam int CTL_CIE  = 3;
  localparam int CTL_TF   = 2;
  localparam int CTL_XF   = 1;
  localparam int CTL_CF   = 0;
  // converter bit position inside peripheral bytes
  localparam int PER_AD   = 6;
  // source index inside the flag bank
  localparam int SRC_CHG  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR  = 2;
  localparam int SRC_ADC  = 3;
  localparam int NUM_SRC  = 4;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_PFLAG = 2'd1,
    SEL_PEN   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic gie;
    logic peie;
    logic tie;
    logic xie;
    logic cie;
    logic adie;
  } irq_en_t;
endpackage

// File: rtl/irq_chg_detect.sv
module irq_chg_detect #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic            snap_load,
  output logic            changed
);
  logic [NPIN-1:0] snap_q;
  logic [NPIN-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_load) snap_q <= pins;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_cmp
    assign diff[i] = pins[i] ^ snap_q[i];
  end

  assign changed = |diff;

  // after a load strobe no mismatch remains while the pins hold still
  p_snap_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_load && $stable(pins)) |=> !changed);
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] sw_wr,
  input  logic [NSRC-1:0] sw_val,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] flags
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic flag_q;
    logic flag_d;

    always_comb begin
      flag_d = flag_q;
      if (sw_wr[i]) flag_d = sw_val[i];
      if (evt[i])   flag_d = 1'b1;  // a set event beats a clearing write
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign flags[i] = flag_q;

    p_event_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);

    p_clear_only_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !sw_wr[i]) |=> flags[i]);
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              pen_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              taken,
  input  logic              ret,
  output irq_en_t           en
);
  irq_en_t en_q;
  irq_en_t en_d;

  always_comb begin
    en_d = en_q;
    if (ctl_wr) begin
      en_d.gie  = wdata[CTL_GIE];
      en_d.peie = wdata[CTL_PEIE];
      en_d.tie  = wdata[CTL_TIE];
      en_d.xie  = wdata[CTL_XIE];
      en_d.cie  = wdata[CTL_CIE];
    end
    if (pen_wr) en_d.adie = wdata[PER_AD];
    if (ret)    en_d.gie  = 1'b1;
    if (taken)  en_d.gie  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en = en_q;

  p_taken_clears_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !en.gie);

  p_return_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !taken) |=> en.gie);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  irq_en_t         en,
  input  logic [NSRC-1:0] flags,
  output logic            irq_req,
  output logic            wake
);
  logic [NSRC-1:0] armed;

  assign armed[SRC_CHG] = en.cie  & flags[SRC_CHG];
  assign armed[SRC_EXT] = en.xie  & flags[SRC_EXT];
  assign armed[SRC_TMR] = en.tie  & flags[SRC_TMR];
  assign armed[SRC_ADC] = en.peie & en.adie & flags[SRC_ADC];

  assign wake    = |armed;
  assign irq_req = en.gie & wake;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int NPIN   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_edge,
  input  logic              adc_done,
  input  logic [NPIN-1:0]   port_pins,
  input  logic              port_rd,
  input  logic              irq_taken,
  input  logic              irq_return,
  output logic              irq_req,
  output logic              wake
);
  localparam logic [DATA_W-1:0] PER_MASK = DATA_W'(1) << PER_AD;

  logic             ctl_wr;
  logic             pfl_wr;
  logic             pen_wr;
  logic             pin_chg;
  logic [NUM_SRC-1:0] sw_wr;
  logic [NUM_SRC-1:0] sw_val;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] flags;
  irq_en_t          en;

  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(SEL_CTL));
  assign pfl_wr = reg_wr && (reg_addr == ADDR_W'(SEL_PFLAG));
  assign pen_wr = reg_wr && (reg_addr == ADDR_W'(SEL_PEN));

  assign sw_wr[SRC_CHG]  = ctl_wr;
  assign sw_wr[SRC_EXT]  = ctl_wr;
  assign sw_wr[SRC_TMR]  = ctl_wr;
  assign sw_wr[SRC_ADC]  = pfl_wr;
  assign sw_val[SRC_CHG] = reg_wdata[CTL_CF];
  assign sw_val[SRC_EXT] = reg_wdata[CTL_XF];
  assign sw_val[SRC_TMR] = reg_wdata[CTL_TF];
  assign sw_val[SRC_ADC] = reg_wdata[PER_AD];

  assign evt[SRC_CHG] = pin_chg;
  assign evt[SRC_EXT] = ext_edge;
  assign evt[SRC_TMR] = tmr_ovf;
  assign evt[SRC_ADC] = adc_done;

  irq_chg_detect #(.NPIN(NPIN)) u_chg (
    .clk(clk), .rst_n(rst_n), .pins(port_pins), .snap_load(port_rd),
    .changed(pin_chg)
  );

  irq_src_flags #(.NSRC(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_val(sw_val), .evt(evt),
    .flags(flags)
  );

  irq_enable_regs #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .pen_wr(pen_wr),
    .wdata(reg_wdata), .taken(irq_taken), .ret(irq_return), .en(en)
  );

  irq_combine #(.NSRC(NUM_SRC)) u_comb (
    .en(en), .flags(flags), .irq_req(irq_req), .wake(wake)
  );

  logic [DATA_W-1:0] ctl_byte;

  always_comb begin
    ctl_byte           = '0;
    ctl_byte[CTL_GIE]  = en.gie;
    ctl_byte[CTL_PEIE] = en.peie;
    ctl_byte[CTL_TIE]  = en.tie;
    ctl_byte[CTL_XIE]  = en.xie;
    ctl_byte[CTL_CIE]  = en.cie;
    ctl_byte[CTL_TF]   = flags[SRC_TMR];
    ctl_byte[CTL_XF]   = flags[SRC_EXT];
    ctl_byte[CTL_CF]   = flags[SRC_CHG];
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(SEL_CTL):   reg_rdata = ctl_byte;
      ADDR_W'(SEL_PFLAG): reg_rdata = flags[SRC_ADC] ? PER_MASK : '0;
      ADDR_W'(SEL_PEN):   reg_rdata = en.adie ? PER_MASK : '0;
      default:            reg_rdata = '0;
    endcase
  end

  p_req_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);

  p_req_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|flags));

  p_change_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg |=> flags[SRC_CHG]);

  p_periph_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(SEL_PFLAG) || reg_addr == ADDR_W'(SEL_PEN))
      |-> ((reg_rdata & ~PER_MASK) == '0));

  p_unused_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(SEL_NONE)) |-> (reg_rdata == '0));
endmodule

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tmr_ovf = 1'b0, ext_edge = 1'b0, adc_done = 1'b0;
  logic [2:0] port_pins = 3'd0;
  logic       port_rd = 1'b0, irq_taken = 1'b0, irq_return = 1'b0;
  logic       irq_req, wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf),
    .ext_edge(ext_edge), .adc_done(adc_done), .port_pins(port_pins),
    .port_rd(port_rd), .irq_taken(irq_taken), .irq_return(irq_return),
    .irq_req(irq_req), .wake(wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1", v, 8'h00);
    end
    chk("R1 req", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R3 events set flags with every enable at 0
    @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    rd(2'd0, v); chk("R3 timer", v, 8'h04);
    @(negedge clk); ext_edge = 1'b1; @(negedge clk); ext_edge = 1'b0;
    rd(2'd0, v); chk("R3 ext", v, 8'h06);
    @(negedge clk); adc_done = 1'b1; @(negedge clk); adc_done = 1'b0;
    rd(2'd1, v); chk("R3 adc", v, 8'h40);
    chk("R3 no req", {6'd0, irq_req, wake}, 8'h00);

    // R4 flags persist, a write clears, an event beats a clearing write
    idle; idle;
    rd(2'd0, v); chk("R4 hold", v, 8'h06);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R4 clear", v, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    rd(2'd0, v); chk("R4 collide", v, 8'h04);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // R5 peripheral padding
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R5 pflag", v, 8'h40);
    wr(2'd2, 8'hBF); rd(2'd2, v); chk("R5 pen pad", v, 8'h00);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R5 pen", v, 8'h40);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R10 unused address
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R10 rd", v, 8'h00);
    rd(2'd0, v); chk("R10 ctl", v, 8'h00);
    rd(2'd1, v); chk("R10 pflag", v, 8'h00);

    // R6 pin change per pin: flag, re-arm, snapshot
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); port_pins[p] = ~port_pins[p];
      idle;
      rd(2'd0, v); chk("R6 set", v, 8'h01);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R6 rearm", v, 8'h01);
      @(negedge clk); port_rd = 1'b1; @(negedge clk); port_rd = 1'b0;
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R6 snapshot", v, 8'h00);
    end

    // R7/R2/R8 exhaustive sweep of control byte x converter enable x flag
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] cb;
        logic ae, af, er, ew;
        cb = 8'(c);
        ae = k[0];
        af = k[1];
        wr(2'd2, {1'b0, ae, 6'd0});
        wr(2'd1, {1'b0, af, 6'd0});
        wr(2'd0, cb);
        ew = (cb[5] & cb[2]) | (cb[4] & cb[1]) | (cb[3] & cb[0]) | (cb[6] & ae & af);
        er = cb[7] & ew;
        rd(2'd0, v); chk("R2 ctl readback", v, cb);
        chk("R7 req", {7'd0, irq_req}, {7'd0, er});
        chk("R8 wake", {7'd0, wake}, {7'd0, ew});
      end
    end
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R9 taken/return and precedence
    wr(2'd0, 8'h80);
    @(negedge clk); irq_taken = 1'b1; @(negedge clk); irq_taken = 1'b0;
    rd(2'd0, v); chk("R9 taken", v, 8'h00);
    @(negedge clk); irq_return = 1'b1; @(negedge clk); irq_return = 1'b0;
    rd(2'd0, v); chk("R9 return", v, 8'h80);
    @(negedge clk); irq_taken = 1'b1; irq_return = 1'b1;
    @(negedge clk); irq_taken = 1'b0; irq_return = 1'b0;
    rd(2'd0, v); chk("R9 taken wins ret", v, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h80; irq_taken = 1'b1;
    @(negedge clk); reg_wr = 1'b0; irq_taken = 1'b0;
    rd(2'd0, v); chk("R9 taken wins wr", v, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; irq_return = 1'b1;
    @(negedge clk); reg_wr = 1'b0; irq_return = 1'b0;
    rd(2'd0, v); chk("R9 ret wins wr", v, 8'h80);
    // request drops after taken with a live source
    wr(2'd0, 8'hA4);
    chk("R9 req live", {7'd0, irq_req}, 8'h01);
    @(negedge clk); irq_taken = 1'b1; @(negedge clk); irq_taken = 1'b0;
    #1 chk("R9 req masked", {6'd0, irq_req, wake}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule